// File: doc/BRIEF.md
# Maskable Interrupt Aggregator

This block gathers a parameterised set of interrupt sources into one host interrupt line. Each source first passes through a two-flop synchroniser. A small per-source state machine then turns it into a status bit. For each source, software picks whether a rising edge, a falling edge or the level of the signal raises the bit. An edge-triggered bit stays set until the host reads the status register. A level-triggered bit simply tracks the synchronised input.

A mask register selects which status bits may raise the interrupt. The host pin can be driven in one of three ways: push-pull active-high, push-pull active-low, or open-drain active-low. In open-drain mode the output enable is asserted only while the interrupt is active, and the driven value is always low, so several devices can share one host input on a wired-OR line. Software reaches the block through a plain parallel register port with separate read and write strobes.

Register map (two address bits): 0 = status (read-only, clear on read), 1 = mask (bit i enables source i), 2 = sensitivity (bits 2i+1:2i belong to source i), 3 = pin mode (bits 1:0).

Per-source states: CELL_IDLE (status 0) and CELL_PEND (status 1).
- Edge mode, CELL_IDLE to CELL_PEND: on the selected edge.
- Edge mode, CELL_PEND to CELL_IDLE: on a status read with no edge in the same cycle.
- Level mode: the state is CELL_PEND while the synchronised level is high, and CELL_IDLE otherwise.

Pin states: PIN_OFF and PIN_ON.
- PIN_OFF to PIN_ON: when the masked status becomes non-zero.
- PIN_ON to PIN_OFF: when the masked status becomes zero.

Top module: `irq_aggregator`

## Requirements
- R1: After reset the status, mask, sensitivity and pin mode registers are all zero, and the pin outputs are irq_o=0 and irq_oe=1.
- R2: With sensitivity code 00 (rising), a low-to-high change on a source sets its status bit, and the bit stays set until it is read. A high-to-low change does not set it.
- R3: With sensitivity code 01 (falling), a high-to-low change on a source sets its status bit. A low-to-high change does not set it.
- R4: With sensitivity code 10 (level), or the reserved code 11 which behaves the same, the status bit equals the synchronised source level, and a read does not clear it while the source is high.
- R5: A read of address 0 returns the status on rd_data one cycle after the strobe and clears the edge-mode bits that were returned. An edge detected in the same cycle as the read stays set and is returned by the next read.
- R6: The interrupt is active one cycle after status AND mask becomes non-zero, and inactive one cycle after it becomes zero. A masked source never activates it.
- R7: With pin mode 00 the interrupt drives irq_o high, and with 01 it drives irq_o low. In both of these modes irq_oe=1 and the inactive level is the opposite value. With 10, or the reserved code 11, irq_o is always 0 and irq_oe equals the active interrupt.
- R8: A write to address 0 has no effect on the status. Writes to the mask, sensitivity and pin mode registers read back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | NUM_SRC | Asynchronous interrupt sources |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register address |
| wr_data | input | 2*NUM_SRC | Write data |
| rd_data | output | 2*NUM_SRC | Read data, valid one cycle after rd_en |
| irq_o | output | 1 | Interrupt pin value |
| irq_oe | output | 1 | Interrupt pin output enable |

## Verification
The hardest case to reach from the ports is an edge that arrives in the same clock cycle as a status read. If that happens, the clear must not drop the new event. The bench changes a source on a falling clock edge and counts the two synchroniser edges. It then raises the read strobe so that it is sampled on exactly the edge where the detector fires. It then expects that read to return 0 for the source and the following read to return 1.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    typedef enum logic [1:0] {
        SENSE_RISE  = 2'b00,
        SENSE_FALL  = 2'b01,
        SENSE_LEVEL = 2'b10,
        SENSE_RSVD  = 2'b11
    } sense_e;

    typedef enum logic [1:0] {
        PMODE_HIGH    = 2'b00,
        PMODE_LOW_PP  = 2'b01,
        PMODE_LOW_OD  = 2'b10,
        PMODE_RSVD    = 2'b11
    } pin_mode_e;

    typedef enum logic {
        CELL_IDLE = 1'b0,
        CELL_PEND = 1'b1
    } cell_state_e;

    typedef enum logic {
        PIN_OFF = 1'b0,
        PIN_ON  = 1'b1
    } pin_state_e;

    localparam logic [1:0] REG_STATUS = 2'd0;
    localparam logic [1:0] REG_MASK   = 2'd1;
    localparam logic [1:0] REG_SENSE  = 2'd2;
    localparam logic [1:0] REG_PMODE  = 2'd3;

endpackage

// File: rtl/irq_sync2.sv
module irq_sync2 #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] meta_q;
    logic [W-1:0] stab_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            stab_q <= '0;
        end else begin
            meta_q <= d_i;
            stab_q <= meta_q;
        end
    end

    assign q_o = stab_q;

endmodule

// File: rtl/irq_src_cell.sv
module irq_src_cell
    import irq_agg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] sense,
    input  logic       lvl,
    input  logic       clr,
    output logic       pend
);

    cell_state_e st_q, st_nx;
    logic        prev_q;
    logic        ev_rise, ev_fall, ev, level_mode;

    assign ev_rise    = lvl & ~prev_q;
    assign ev_fall    = ~lvl & prev_q;
    assign level_mode = sense[1];

    always_comb begin
        unique case (sense_e'(sense))
            SENSE_RISE:  ev = ev_rise;
            SENSE_FALL:  ev = ev_fall;
            SENSE_LEVEL: ev = 1'b0;
            SENSE_RSVD:  ev = 1'b0;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= CELL_IDLE;
            prev_q <= 1'b0;
        end else begin
            st_q   <= st_nx;
            prev_q <= lvl;
        end
    end

    // Next state
    always_comb begin
        st_nx = st_q;
        if (level_mode) begin
            st_nx = lvl ? CELL_PEND : CELL_IDLE;
        end else begin
            unique case (st_q)
                CELL_IDLE: if (ev) st_nx = CELL_PEND;
                CELL_PEND: if (clr && !ev) st_nx = CELL_IDLE;
            endcase
        end
    end

    // Output
    always_comb begin
        pend = (st_q == CELL_PEND);
    end

    // R2: a rising edge in rising mode is always captured
    a_r2_rise_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (sense == 2'b00 && lvl && !prev_q) |=> pend);

    // R3: a falling edge in falling mode is always captured
    a_r3_fall_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (sense == 2'b01 && !lvl && prev_q) |=> pend);

    // R4: a level-mode bit drops once the source is low
    a_r4_level_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (level_mode && !lvl) |=> !pend);

    // R5: an edge-mode bit stays pending while no read clears it
    a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (!level_mode && pend && !clr && $stable(sense)) |=> pend);

endmodule

// File: rtl/irq_pin_drv.sv
module irq_pin_drv
    import irq_agg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode,
    input  logic       active,
    output logic       asserted,
    output logic       irq_o,
    output logic       irq_oe
);

    pin_state_e st_q, st_nx;

    always_comb begin
        unique case (st_q)
            PIN_OFF: st_nx = active ? PIN_ON  : PIN_OFF;
            PIN_ON:  st_nx = active ? PIN_ON  : PIN_OFF;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= PIN_OFF;
        else        st_q <= st_nx;
    end

    // Outputs
    always_comb begin
        asserted = (st_q == PIN_ON);
        unique case (pin_mode_e'(mode))
            PMODE_HIGH: begin
                irq_o  = asserted;
                irq_oe = 1'b1;
            end
            PMODE_LOW_PP: begin
                irq_o  = ~asserted;
                irq_oe = 1'b1;
            end
            PMODE_LOW_OD, PMODE_RSVD: begin
                irq_o  = 1'b0;
                irq_oe = asserted;
            end
        endcase
    end

    // R7: open-drain never drives high
    a_r7_od_low_only: assert property (@(posedge clk) disable iff (!rst_n)
        mode[1] |-> !irq_o);

    // R7: push-pull modes always drive
    a_r7_pp_driven: assert property (@(posedge clk) disable iff (!rst_n)
        !mode[1] |-> irq_oe);

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
    import irq_agg_pkg::*;
#(
    parameter int NUM_SRC = 8,
    localparam int DATA_W = 2 * NUM_SRC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq_o,
    output logic              irq_oe
);

    logic [NUM_SRC-1:0] sync_lvl;
    logic [NUM_SRC-1:0] status;
    logic [NUM_SRC-1:0] mask_q;
    logic [DATA_W-1:0]  sense_q;
    logic [1:0]         pmode_q;
    logic               status_rd;
    logic               irq_active;
    logic               pin_asserted;

    irq_sync2 #(.W(NUM_SRC)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (src_i),
        .q_o   (sync_lvl)
    );

    assign status_rd = rd_en && (addr == REG_STATUS);

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_cell
        irq_src_cell u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .sense (sense_q[2*i +: 2]),
            .lvl   (sync_lvl[i]),
            .clr   (status_rd),
            .pend  (status[i])
        );
    end

    // Configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q  <= '0;
            sense_q <= '0;
            pmode_q <= '0;
        end else if (wr_en) begin
            unique case (addr)
                REG_STATUS: ;
                REG_MASK:   mask_q  <= wr_data[NUM_SRC-1:0];
                REG_SENSE:  sense_q <= wr_data;
                REG_PMODE:  pmode_q <= wr_data[1:0];
            endcase
        end
    end

    // Read data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_en) begin
            unique case (addr)
                REG_STATUS: rd_data <= DATA_W'(status);
                REG_MASK:   rd_data <= DATA_W'(mask_q);
                REG_SENSE:  rd_data <= sense_q;
                REG_PMODE:  rd_data <= DATA_W'(pmode_q);
            endcase
        end
    end

    assign irq_active = |(status & mask_q);

    irq_pin_drv u_pin (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (pmode_q),
        .active   (irq_active),
        .asserted (pin_asserted),
        .irq_o    (irq_o),
        .irq_oe   (irq_oe)
    );

    // R6: pin follows masked status with one cycle of delay
    a_r6_pin_on: assert property (@(posedge clk) disable iff (!rst_n)
        (|(status & mask_q)) |=> pin_asserted);

    a_r6_pin_off: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(status & mask_q)) |=> !pin_asserted);

    // R8: a status-address write alone changes no configuration
    a_r8_status_wr_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == REG_STATUS) |=> ($stable(mask_q) && $stable(sense_q) && $stable(pmode_q)));

endmodule

// File: tb/tb_irq_aggregator.sv
`timescale 1ns/100ps
module tb_irq_aggregator;

    localparam int N  = 8;
    localparam int DW = 2 * N;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  src_i = '0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [1:0]    addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic          irq_o, irq_oe;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    irq_aggregator #(.NUM_SRC(N)) dut (
        .clk(clk), .rst_n(rst_n), .src_i(src_i), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .irq_o(irq_o), .irq_oe(irq_oe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [DW-1:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [DW-1:0] d;
        chk("R1 irq_o", 32'(irq_o), 32'd0);
        chk("R1 irq_oe", 32'(irq_oe), 32'd1);
        rd(2'd0, d); chk("R1 status", 32'(d), 32'd0);
        rd(2'd1, d); chk("R1 mask", 32'(d), 32'd0);
        rd(2'd2, d); chk("R1 sense", 32'(d), 32'd0);
        rd(2'd3, d); chk("R1 mode", 32'(d), 32'd0);
    endtask

    task automatic t_rise();
        logic [DW-1:0] d;
        wr(2'd2, '0);
        src_i[0] = 1'b1; settle();
        rd(2'd0, d); chk("R2 rise sets", 32'(d[0]), 32'd1);
        rd(2'd0, d); chk("R2 cleared after read", 32'(d[0]), 32'd0);
        src_i[0] = 1'b0; settle();
        rd(2'd0, d); chk("R2 fall ignored", 32'(d[0]), 32'd0);
    endtask

    task automatic t_fall();
        logic [DW-1:0] d;
        wr(2'd2, 16'h01 << 6);
        src_i[3] = 1'b1; settle();
        rd(2'd0, d); chk("R3 rise ignored", 32'(d[3]), 32'd0);
        src_i[3] = 1'b0; settle();
        rd(2'd0, d); chk("R3 fall sets", 32'(d[3]), 32'd1);
        rd(2'd0, d); chk("R3 cleared", 32'(d[3]), 32'd0);
        wr(2'd2, '0);
    endtask

    task automatic t_level();
        logic [DW-1:0] d;
        wr(2'd2, (16'h2 << 2) | (16'h3 << 4));
        src_i[1] = 1'b1; src_i[2] = 1'b1; settle();
        rd(2'd0, d); chk("R4 level high", 32'(d[2:1]), 32'd3);
        rd(2'd0, d); chk("R4 not cleared while high", 32'(d[2:1]), 32'd3);
        src_i[1] = 1'b0; src_i[2] = 1'b0; settle();
        rd(2'd0, d); chk("R4 follows low", 32'(d[2:1]), 32'd0);
        wr(2'd2, '0);
    endtask

    task automatic t_race();
        logic [DW-1:0] d;
        rd(2'd0, d);
        @(negedge clk); src_i[5] = 1'b1;
        @(negedge clk);
        @(negedge clk); rd_en = 1'b1; addr = 2'd0;
        @(negedge clk); rd_en = 1'b0;
        chk("R5 race read sees old", 32'(rd_data[5]), 32'd0);
        rd(2'd0, d); chk("R5 race event kept", 32'(d[5]), 32'd1);
        src_i[5] = 1'b0; settle();
        rd(2'd0, d);
    endtask

    task automatic t_mask_pin();
        logic [DW-1:0] d;
        wr(2'd3, 16'd0);
        src_i[6] = 1'b1; settle();
        chk("R6 masked quiet", 32'(irq_o), 32'd0);
        wr(2'd1, 16'h40);
        @(negedge clk);
        chk("R6 unmasked asserts", 32'(irq_o), 32'd1);
        chk("R7 high oe", 32'(irq_oe), 32'd1);
        wr(2'd3, 16'd1);
        chk("R7 low pp asserted", 32'({irq_o, irq_oe}), 32'b01);
        wr(2'd3, 16'd2);
        chk("R7 od asserted", 32'({irq_o, irq_oe}), 32'b01);
        wr(2'd3, 16'd3);
        chk("R7 rsvd as od", 32'({irq_o, irq_oe}), 32'b01);
        rd(2'd0, d);
        @(negedge clk);
        chk("R7 od released", 32'({irq_o, irq_oe}), 32'b00);
        wr(2'd3, 16'd1);
        chk("R7 low pp idle", 32'({irq_o, irq_oe}), 32'b11);
        wr(2'd3, 16'd0);
        chk("R6 deasserted", 32'({irq_o, irq_oe}), 32'b01);
        src_i[6] = 1'b0; settle();
    endtask

    task automatic t_regs();
        logic [DW-1:0] d;
        wr(2'd1, 16'h00A5);
        wr(2'd2, 16'h1234);
        wr(2'd3, 16'h0002);
        wr(2'd0, 16'hFFFF);
        rd(2'd0, d); chk("R8 status write ignored", 32'(d), 32'd0);
        rd(2'd1, d); chk("R8 mask readback", 32'(d), 32'h00A5);
        rd(2'd2, d); chk("R8 sense readback", 32'(d), 32'h1234);
        rd(2'd3, d); chk("R8 mode readback", 32'(d), 32'h0002);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_rise();
        t_fall();
        t_level();
        t_race();
        t_mask_pin();
        t_regs();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule